// File: doc/BRIEF.md
# Decimal Adjust Unit

This block turns the binary result of an 8-bit add or subtract back into valid packed BCD. It takes the accumulator byte together with the three flags left by the previous arithmetic operation: subtract, half-carry and carry. It then applies a correction of 0x06 to the low digit, 0x60 to the high digit, or both. The subtract flag picks whether the corrections are added or taken away, so a single unit serves both directions. The unit also produces the new zero, half-carry and carry flags and passes the subtract flag through unchanged.

The correction is one combinational stage. A thin register stage around it captures the adjusted byte and flags at the clock edge where the execute strobe is high, and holds them until the next strobe. Each adjust operation therefore takes one clock. An asynchronous active-low reset clears that register stage, and the reset is released in step with the clock.

Top module: `dec_adjust_unit`

## Requirements
- R1: While reset is held, and until the first strobe after reset, every output is 0 (byte 0x00, all flags 0).
- R2: With the subtract flag clear, 0x06 is added when the half-carry flag is set or the low nibble of the input is above 9. 0x60 is added when the carry flag is set or the input byte is above 0x99. Arithmetic is modulo 256.
- R3: With the subtract flag set, the same two conditions subtract 0x06 and 0x60 instead, modulo 256.
- R4: Both conditions are judged on the original input byte, so both corrections can apply in one operation (for example, 0x9A with all flags clear gives 0x00).
- R5: An input that meets neither condition passes through unchanged.
- R6: The new carry is the incoming carry OR (input byte above 0x99).
- R7: The new half-carry is bit 4 of the input XOR bit 4 of the adjusted byte.
- R8: The zero flag is 1 exactly when the adjusted byte is 0x00, and the subtract output equals the subtract input that was captured.
- R9: Outputs take the new values at the clock edge where the execute strobe is high. They hold their values at every edge where it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe; capture the adjusted result at this edge |
| acc_i | input | 8 | Accumulator byte to adjust |
| sub_i | input | 1 | Incoming subtract flag |
| half_i | input | 1 | Incoming half-carry flag |
| carry_i | input | 1 | Incoming carry flag |
| acc_o | output | 8 | Adjusted accumulator byte |
| zero_o | output | 1 | New zero flag |
| sub_o | output | 1 | Subtract flag passed through |
| half_o | output | 1 | New half-carry flag |
| carry_o | output | 1 | New carry flag |

## Verification
Directed bytes come first. Some sit just inside and just outside each condition, such as a low nibble of 9 against 0xA, and 0x99 against 0x9A. These separate a wrong comparison limit from a wrong correction. Bytes that trigger both corrections at once, and bytes that wrap through zero, show whether the conditions are judged on the original input and whether the arithmetic wraps modulo 256. A full sweep of all 256 bytes under each of the eight flag combinations is checked against a reference model built from the requirements. Idle cycles with changing inputs confirm that outputs move only on the strobe.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
  localparam int BYTE_W     = 8;
  localparam int NIB_W      = BYTE_W / 2;
  localparam int NIB_LIMIT  = 9;
  localparam int BYTE_LIMIT = 16 * NIB_LIMIT + NIB_LIMIT;
  localparam logic [NIB_W-1:0] DIGIT_FIX = NIB_W'(6);

  typedef struct packed {
    logic zero;
    logic sub;
    logic half;
    logic carry;
  } flags_t;
endpackage

// File: rtl/dadj_rst_sync.sv
module dadj_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dadj_detect.sv
module dadj_detect
  import dadj_pkg::*;
(
  input  logic [BYTE_W-1:0] acc_i,
  input  logic              half_i,
  input  logic              carry_i,
  output logic              fix_lo_o,
  output logic              fix_hi_o,
  output logic              over_o
);
  logic lo_digit_big;

  always_comb begin
    lo_digit_big = (acc_i[NIB_W-1:0] > NIB_W'(NIB_LIMIT));
    over_o       = (acc_i > BYTE_W'(BYTE_LIMIT));
    fix_lo_o     = half_i  | lo_digit_big;
    fix_hi_o     = carry_i | over_o;
  end
endmodule

// File: rtl/dadj_core.sv
module dadj_core
  import dadj_pkg::*;
(
  input  logic [BYTE_W-1:0] acc_i,
  input  logic              sub_i,
  input  logic              half_i,
  input  logic              carry_i,
  output logic [BYTE_W-1:0] acc_o,
  output flags_t            flags_o
);
  logic              fix_lo;
  logic              fix_hi;
  logic              over;
  logic [BYTE_W-1:0] corr;
  logic [BYTE_W-1:0] operand;
  logic [BYTE_W-1:0] sum;

  dadj_detect u_detect (
    .acc_i    (acc_i),
    .half_i   (half_i),
    .carry_i  (carry_i),
    .fix_lo_o (fix_lo),
    .fix_hi_o (fix_hi),
    .over_o   (over)
  );

  // One adder serves both directions: subtract is add of the two's complement.
  always_comb begin
    corr[NIB_W-1:0]      = fix_lo ? DIGIT_FIX : '0;
    corr[BYTE_W-1:NIB_W] = fix_hi ? DIGIT_FIX : '0;
    operand              = corr ^ {BYTE_W{sub_i}};
    sum                  = acc_i + operand + BYTE_W'(sub_i);
  end

  always_comb begin
    acc_o         = sum;
    flags_o.zero  = (sum == '0);
    flags_o.sub   = sub_i;
    flags_o.half  = acc_i[NIB_W] ^ sum[NIB_W];
    flags_o.carry = carry_i | over;
  end
endmodule

// File: rtl/dadj_result_reg.sv
module dadj_result_reg
  import dadj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] acc_d_i,
  input  flags_t            flags_d_i,
  output logic [BYTE_W-1:0] acc_q_o,
  output flags_t            flags_q_o
);
  logic [BYTE_W-1:0] acc_nxt;
  flags_t            flags_nxt;

  always_comb begin
    acc_nxt   = acc_q_o;
    flags_nxt = flags_q_o;
    if (load_i) begin
      acc_nxt   = acc_d_i;
      flags_nxt = flags_d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q_o   <= '0;
      flags_q_o <= '0;
    end else begin
      acc_q_o   <= acc_nxt;
      flags_q_o <= flags_nxt;
    end
  end
endmodule

// File: rtl/dec_adjust_unit.sv
module dec_adjust_unit
  import dadj_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic              sub_i,
  input  logic              half_i,
  input  logic              carry_i,
  output logic [BYTE_W-1:0] acc_o,
  output logic              zero_o,
  output logic              sub_o,
  output logic              half_o,
  output logic              carry_o
);
  logic              rst_sync_n;
  logic [BYTE_W-1:0] adj_acc;
  flags_t            adj_flags;
  flags_t            flags_q;

  dadj_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dadj_core u_core (
    .acc_i   (acc_i),
    .sub_i   (sub_i),
    .half_i  (half_i),
    .carry_i (carry_i),
    .acc_o   (adj_acc),
    .flags_o (adj_flags)
  );

  dadj_result_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (exec_i),
    .acc_d_i   (adj_acc),
    .flags_d_i (adj_flags),
    .acc_q_o   (acc_o),
    .flags_q_o (flags_q)
  );

  assign zero_o  = flags_q.zero;
  assign sub_o   = flags_q.sub;
  assign half_o  = flags_q.half;
  assign carry_o = flags_q.carry;
endmodule

// File: rtl/dadj_checker.sv
module dadj_checker (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       exec_i,
  input logic [7:0] acc_i,
  input logic       sub_i,
  input logic       half_i,
  input logic       carry_i,
  input logic [7:0] acc_o,
  input logic       zero_o,
  input logic       sub_o,
  input logic       half_o,
  input logic       carry_o
);
  // R1
  always_comb begin
    if (!rst_sync_n) begin
      reset_clear_chk: assert ({acc_o, zero_o, sub_o, half_o, carry_o} == '0);
    end
  end

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !exec_i |=> $stable({acc_o, zero_o, sub_o, half_o, carry_o}));

  // R6
  carry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && (carry_i || acc_i > 8'h99)) |=> carry_o);

  // R6
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && !carry_i && acc_i <= 8'h99) |=> !carry_o);

  // R7
  half_rule_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exec_i |=> (half_o == ($past(acc_i[4]) ^ acc_o[4])));

  // R8
  zero_rule_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exec_i |=> (zero_o == (acc_o == 8'h00)));

  // R8
  sub_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exec_i |=> (sub_o == $past(sub_i)));

  // R5
  no_fix_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && !half_i && !carry_i && acc_i[3:0] <= 4'd9 && acc_i <= 8'h99)
    |=> (acc_o == $past(acc_i)));
endmodule

bind dec_adjust_unit dadj_checker u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .exec_i     (exec_i),
  .acc_i      (acc_i),
  .sub_i      (sub_i),
  .half_i     (half_i),
  .carry_i    (carry_i),
  .acc_o      (acc_o),
  .zero_o     (zero_o),
  .sub_o      (sub_o),
  .half_o     (half_o),
  .carry_o    (carry_o)
);

// File: tb/dec_adjust_unit_bench.sv
module dec_adjust_unit_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       exec_i;
  logic [7:0] acc_i;
  logic       sub_i, half_i, carry_i;
  logic [7:0] acc_o;
  logic       zero_o, sub_o, half_o, carry_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_adjust_unit u_dec_adjust_unit (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .acc_i(acc_i),
    .sub_i(sub_i), .half_i(half_i), .carry_i(carry_i),
    .acc_o(acc_o), .zero_o(zero_o), .sub_o(sub_o),
    .half_o(half_o), .carry_o(carry_o)
  );

  // Reference model written from the requirement list: {byte, z, n, h, c}
  function automatic logic [11:0] ref_model(input logic [7:0] a, input logic n,
                                            input logic h, input logic c);
    logic [7:0] r;
    logic       big;
    r   = a;
    big = (a > 8'h99);
    if (h || a[3:0] > 4'd9) r = n ? r - 8'h06 : r + 8'h06;
    if (c || big)           r = n ? r - 8'h60 : r + 8'h60;
    return {r, (r == 8'h00), n, a[4] ^ r[4], c | big};
  endfunction

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got byte=%02h z/n/h/c=%04b expected byte=%02h z/n/h/c=%04b",
               req, got[11:4], got[3:0], exp[11:4], exp[3:0]);
    end
  endtask

  function automatic logic [11:0] outs();
    return {acc_o, zero_o, sub_o, half_o, carry_o};
  endfunction

  task automatic run_op(input logic [7:0] a, input logic n, input logic h, input logic c);
    @(negedge clk);
    acc_i = a; sub_i = n; half_i = h; carry_i = c; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  task automatic op_expect(input string req, input logic [7:0] a, input logic n,
                           input logic h, input logic c, input logic [7:0] exp_byte);
    run_op(a, n, h, c);
    check(req, outs(), ref_model(a, n, h, c));
    total++;
    if (acc_o !== exp_byte) begin
      bad++;
      $display("FAIL %s: byte got=%02h expected=%02h", req, acc_o, exp_byte);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; exec_i = 1'b0; acc_i = 8'h55; sub_i = 1'b1; half_i = 1'b1; carry_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 during reset", outs(), 12'h000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", outs(), 12'h000);
  endtask

  task automatic t_add();
    op_expect("R5 plain add", 8'h15, 1'b0, 1'b0, 1'b0, 8'h15);
    op_expect("R5 edge 0x99", 8'h99, 1'b0, 1'b0, 1'b0, 8'h99);
    op_expect("R2 low nibble A", 8'h0A, 1'b0, 1'b0, 1'b0, 8'h10);
    op_expect("R2 half flag", 8'h12, 1'b0, 1'b1, 1'b0, 8'h18);
    op_expect("R2 high over", 8'hA3, 1'b0, 1'b0, 1'b0, 8'h03);
    op_expect("R2 carry flag", 8'h25, 1'b0, 1'b0, 1'b1, 8'h85);
  endtask

  task automatic t_sub();
    op_expect("R3 half flag", 8'h0F, 1'b1, 1'b1, 1'b0, 8'h09);
    op_expect("R3 carry flag", 8'hF0, 1'b1, 1'b0, 1'b1, 8'h90);
    op_expect("R3 wrap below zero", 8'h03, 1'b1, 1'b1, 1'b1, 8'h9D);
    op_expect("R3 both from byte", 8'h9A, 1'b1, 1'b0, 1'b0, 8'h34);
  endtask

  task automatic t_both();
    op_expect("R4 both to zero", 8'h9A, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R8 zero and R6 carry after 0x9A", outs(), {8'h00, 1'b1, 1'b0, 1'b1, 1'b1});
    op_expect("R4 both wrap", 8'hFF, 1'b0, 1'b0, 1'b0, 8'h65);
    op_expect("R7 half flip", 8'h0A, 1'b0, 1'b0, 1'b0, 8'h10);
    check("R7 half set", {7'h0, half_o, 4'h0}, {7'h0, 1'b1, 4'h0});
  endtask

  task automatic t_hold();
    logic [11:0] snap;
    run_op(8'h47, 1'b1, 1'b0, 1'b1);
    snap = outs();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      acc_i = 8'(k * 37); sub_i = ~sub_i; half_i = k[0]; carry_i = ~k[0];
    end
    @(negedge clk);
    check("R9 hold while idle", outs(), snap);
    check("R9 held value", snap, ref_model(8'h47, 1'b1, 1'b0, 1'b1));
  endtask

  task automatic t_sweep();
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < 256; a++) begin
        run_op(8'(a), f[2], f[1], f[0]);
        check("R2 R3 R6 R7 R8 sweep", outs(), ref_model(8'(a), f[2], f[1], f[0]));
      end
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_both();
    t_hold();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule